// File: doc/BRIEF.md
# Sequential and Strided DMA Reader

This block fetches packet payload out of memory on behalf of a network interface. A single descriptor, presented with a one-cycle start pulse, names a byte base address, a length in 32-bit words and an access pattern. The pattern is one of three. Sequential mode walks consecutive words. Strided-word mode reads one word per element and steps by a byte stride. Strided-double mode reads each element as two adjacent words and then moves the element pointer by the stride.

Before each read request leaves the block, one slot of the receive buffer is reserved against a credit count. The downstream consumer returns credits with a release strobe. Every accepted request pushes its buffer slot number into an eight-entry pending queue. Memory answers in request order over a 32-bit read-data bus. When each word arrives, the head of the queue is popped and drives the buffer write select, so the word lands in the slot that was reserved for it. A descriptor with bad parameters is refused with an error pulse. A good one ends with a done pulse once its last word has been written.

Top module: `strided_dma_reader`

## Requirements
- R1: In sequential mode (`strided`=0) the k-th request of a descriptor carries address base+4k.
- R2: In strided-word mode (`strided`=1, `dbl`=0) the k-th request carries address base+k*stride.
- R3: In strided-double mode (`strided`=1, `dbl`=1), element m is read as two consecutive requests at base+m*stride and base+m*stride+4.
- R4: The buffer holds BUF_SLOTS (16) slots, and all of them are free after reset. Each accepted request uses one slot, and each `buf_free` pulse returns one. `mem_req` stays low while no slot is free.
- R5: At most PQ_DEPTH (8) requests are outstanding, meaning accepted but not yet returned. `mem_req` stays low while that many are pending.
- R6: Each word returned with `mem_rvalid` is written with `buf_we`=1 in the same cycle. `buf_data` equals `mem_rdata`, and `buf_sel` equals the slot reserved for the matching request. Slots are handed out in circular order starting from 0 after reset, and the order carries over from one descriptor to the next.
- R7: `done` is high for exactly one cycle, in the cycle after the descriptor's last word was returned. `busy` is low from that same cycle onward.
- R8: A start is refused with a one-cycle `err` pulse in the following cycle, and no request is issued, if any of these holds: base[1:0]≠0, count=0, strided with stride[1:0]≠0, or strided-double with an odd count.
- R9: A start pulse while `busy` is high has no effect on the transfer in progress.
- R10: A request that is not granted stays asserted with the same address until `mem_gnt` is high.
- R11: After reset, `busy`, `mem_req`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Descriptor start pulse |
| base_addr | input | AW | Byte base address |
| word_count | input | CW | Number of 32-bit words to read |
| strided | input | 1 | 1 = strided mode, 0 = sequential |
| dbl | input | 1 | Strided element is a double word |
| stride | input | AW | Byte stride between elements |
| busy | output | 1 | Descriptor in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | AW | Read request byte address |
| mem_gnt | input | 1 | Request accepted by memory |
| mem_rvalid | input | 1 | Read data valid (in request order) |
| mem_rdata | input | 32 | Read data |
| buf_we | output | 1 | Buffer write strobe |
| buf_sel | output | $clog2(BUF_SLOTS) | Buffer slot select for the returned word |
| buf_data | output | 32 | Buffer write data |
| buf_free | input | 1 | Consumer returns one buffer slot |

## Verification
The busiest collision is a new request being granted in the same cycle as an earlier word coming back. In that cycle the pending queue is pushed and popped at once, and the credit count can also be raised by `buf_free` while a grant lowers it. The bench provokes this by running grant and return patterns of different periods, so grants and returns sometimes line up and sometimes alternate. It judges every grant against a model of the expected address and every write against a model of the expected slot and data. One run uses slow returns so the pending queue stays full while pushes and pops keep meeting. Another holds back slot releases and then lets them flow while requests resume.

// File: rtl/strided_dma_reader.sv
module strided_dma_reader #(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int PQ_DEPTH  = 8,
  parameter int BUF_SLOTS = 16,
  localparam int SW = $clog2(BUF_SLOTS),
  localparam int PW = $clog2(PQ_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] word_count,
  input  logic          strided,
  input  logic          dbl,
  input  logic [AW-1:0] stride,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          buf_we,
  output logic [SW-1:0] buf_sel,
  output logic [31:0]   buf_data,
  input  logic          buf_free
);

  logic          busy_q, done_q, err_q;
  logic [AW-1:0] addr_q, stride_q;
  logic          strided_q, dbl_q, half_q;
  logic [CW-1:0] to_issue_q, to_recv_q;
  logic [SW-1:0] pq_mem [PQ_DEPTH];
  logic [PW-1:0] pq_wp, pq_rp;
  logic [PW:0]   pq_cnt;
  logic [SW:0]   credits;
  logic [SW-1:0] alloc_q;

  logic          bad, accept, issue, pop, free_ok;
  logic [AW-1:0] step;

  assign bad = (base_addr[1:0] != 2'b00) || (word_count == '0) ||
               (strided && stride[1:0] != 2'b00) ||
               (strided && dbl && word_count[0]);
  assign accept = start && !busy_q;

  assign mem_req  = busy_q && (to_issue_q != '0) &&
                    (pq_cnt != (PW+1)'(PQ_DEPTH)) && (credits != '0);
  assign mem_addr = addr_q;
  assign issue    = mem_req && mem_gnt;

  assign pop      = mem_rvalid && (pq_cnt != '0);
  assign buf_we   = pop;
  assign buf_sel  = pq_mem[pq_rp];
  assign buf_data = mem_rdata;

  assign free_ok  = buf_free && (credits != (SW+1)'(BUF_SLOTS));

  always_comb begin
    if (!strided_q)          step = AW'(4);
    else if (!dbl_q)         step = stride_q;
    else if (!half_q)        step = AW'(4);
    else                     step = stride_q - AW'(4);
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (issue) pq_mem[pq_wp] <= alloc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      addr_q     <= '0;
      stride_q   <= '0;
      strided_q  <= 1'b0;
      dbl_q      <= 1'b0;
      half_q     <= 1'b0;
      to_issue_q <= '0;
      to_recv_q  <= '0;
      pq_wp      <= '0;
      pq_rp      <= '0;
      pq_cnt     <= '0;
      credits    <= (SW+1)'(BUF_SLOTS);
      alloc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (bad) begin
          err_q <= 1'b1;
        end else begin
          busy_q     <= 1'b1;
          addr_q     <= base_addr;
          stride_q   <= stride;
          strided_q  <= strided;
          dbl_q      <= dbl;
          half_q     <= 1'b0;
          to_issue_q <= word_count;
          to_recv_q  <= word_count;
        end
      end
      if (issue) begin
        pq_wp      <= pq_wp + 1'b1;
        alloc_q    <= alloc_q + 1'b1;
        addr_q     <= addr_q + step;
        half_q     <= (strided_q && dbl_q) ? !half_q : 1'b0;
        to_issue_q <= to_issue_q - 1'b1;
      end
      if (pop) begin
        pq_rp     <= pq_rp + 1'b1;
        to_recv_q <= to_recv_q - 1'b1;
        if (to_recv_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
      pq_cnt  <= pq_cnt + (PW+1)'(issue) - (PW+1)'(pop);
      credits <= credits + (SW+1)'(free_ok) - (SW+1)'(issue);
    end
  end

endmodule

module dma_reader_checker #(
  parameter int AW        = 32,
  parameter int PQ_DEPTH  = 8,
  parameter int BUF_SLOTS = 16,
  localparam int SW = $clog2(BUF_SLOTS),
  localparam int PW = $clog2(PQ_DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          buf_we,
  input logic [PW:0]   pq_cnt,
  input logic [SW:0]   credits
);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_cnt == (PW+1)'(PQ_DEPTH)) |-> !mem_req);

  assert_pending_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pq_cnt <= (PW+1)'(PQ_DEPTH));

  assert_no_credit_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (credits == '0) |-> !mem_req);

  assert_write_has_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (pq_cnt != '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !mem_req));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

endmodule

bind strided_dma_reader dma_reader_checker #(
  .AW(AW), .PQ_DEPTH(PQ_DEPTH), .BUF_SLOTS(BUF_SLOTS)
) u_dma_reader_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
  .buf_we(buf_we), .pq_cnt(pq_cnt), .credits(credits)
);

// File: tb/test_strided_dma_reader.sv
module test_strided_dma_reader;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic          strided = 1'b0;
  logic          dbl = 1'b0;
  logic [AW-1:0] stride = '0;
  logic          busy, done, err, mem_req, buf_we;
  logic [AW-1:0] mem_addr;
  logic          mem_gnt = 1'b0;
  logic          mem_rvalid = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic [SW-1:0] buf_sel;
  logic [31:0]   buf_data;
  logic          buf_free = 1'b0;

  strided_dma_reader #(.AW(AW), .CW(CW), .PQ_DEPTH(8), .BUF_SLOTS(16)) i_strided_dma_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_count(word_count), .strided(strided), .dbl(dbl), .stride(stride),
    .busy(busy), .done(done), .err(err), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .buf_we(buf_we), .buf_sel(buf_sel), .buf_data(buf_data), .buf_free(buf_free)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [31:0] V_BASE   [NV] = '{32'h100, 32'h200, 32'h400, 32'h1000, 32'h3000, 32'h5008};
  localparam int          V_CNT    [NV] = '{5, 4, 6, 16, 7, 8};
  localparam bit          V_STR    [NV] = '{0, 1, 1, 0, 1, 1};
  localparam bit          V_DBL    [NV] = '{0, 0, 1, 0, 0, 1};
  localparam logic [31:0] V_STRIDE [NV] = '{32'h0, 32'h10, 32'h20, 32'h0, 32'hC, 32'h100};
  localparam int          V_GMODE  [NV] = '{0, 1, 0, 0, 3, 1};
  localparam int          V_RMODE  [NV] = '{0, 3, 1, 2, 0, 2};
  localparam bit          V_FULL   [NV] = '{0, 0, 0, 1, 0, 0};
  localparam bit          V_IGN    [NV] = '{0, 0, 0, 0, 1, 0};

  logic [31:0] d_base, d_stride;
  int          d_cnt, gmode, rmode, hold;
  bit          d_str, d_dbl, ign, done_seen;
  int          tick, iss_idx, recv_idx, exp_slot, backlog, maxq;
  logic [31:0] mq[$];
  bit          prev_stall;
  logic [31:0] prev_addr;

  function automatic logic [31:0] exp_addr(input int k);
    if (!d_str) return d_base + 32'(4 * k);
    if (!d_dbl) return d_base + 32'(k) * d_stride;
    return d_base + 32'(k / 2) * d_stride + 32'(4 * (k % 2));
  endfunction

  function automatic logic [31:0] data_of(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic bit pat_ok(input int mode, input int t);
    case (mode)
      0: return 1'b1;
      1: return (t % 2) == 0;
      2: return (t % 4) == 0;
      default: return (t % 3) != 0;
    endcase
  endfunction

  function automatic string mode_tag();
    if (!d_str) return "R1";
    if (!d_dbl) return "R2";
    return "R3";
  endfunction

  task automatic cycle();
    @(negedge clk);
    tick++;
    if (done) begin
      done_seen = 1'b1;
      chk(recv_idx == d_cnt, "R7", "done after last word", 32'(recv_idx), 32'(d_cnt));
      chk(!busy, "R7", "busy low with done", 32'(busy), 32'h0);
    end
    if (prev_stall)
      chk(mem_req && mem_addr == prev_addr, "R10", "stalled request held", mem_addr, prev_addr);
    start = ign && (tick == 3);
    if (start) base_addr = 32'h8000;
    mem_rvalid = 1'b0;
    if (mq.size() > 0 && pat_ok(rmode, tick)) begin
      mem_rvalid = 1'b1;
      mem_rdata  = data_of(mq.pop_front());
    end
    buf_free = 1'b0;
    if (backlog > 0 && tick >= hold) begin
      buf_free = 1'b1;
      backlog--;
    end
    mem_gnt = pat_ok(gmode, tick);
    #1;
    if (hold > 0 && tick == hold - 1) begin
      chk(iss_idx == 16, "R4", "requests before slot release", 32'(iss_idx), 32'd16);
      chk(!mem_req, "R4", "no request without free slot", 32'(mem_req), 32'h0);
    end
    prev_stall = mem_req && !mem_gnt;
    prev_addr  = mem_addr;
    if (mem_req && mem_gnt) begin
      chk(mem_addr == exp_addr(iss_idx), mode_tag(), "request address", mem_addr, exp_addr(iss_idx));
      mq.push_back(mem_addr);
      iss_idx++;
      if (mq.size() > maxq) maxq = mq.size();
    end
    if (buf_we) begin
      chk(buf_sel == SW'(exp_slot) && buf_data == data_of(exp_addr(recv_idx)), "R6",
          "slot/data", {buf_sel, buf_data[27:0]}, {SW'(exp_slot), data_of(exp_addr(recv_idx))[27:0]});
      exp_slot++;
      recv_idx++;
      backlog++;
    end
  endtask

  task automatic run(input logic [31:0] b, input int c, input bit s, input bit d,
                     input logic [31:0] st, input int g, input int r, input bit ig, input int h);
    d_base = b; d_cnt = c; d_str = s; d_dbl = d; d_stride = st;
    gmode = g; rmode = r; ign = ig; hold = h;
    tick = 0; iss_idx = 0; recv_idx = 0; maxq = 0; done_seen = 0; prev_stall = 0;
    @(negedge clk);
    base_addr = b; word_count = CW'(c); strided = s; dbl = d; stride = st; start = 1'b1;
    while (!done_seen && tick < 2000) cycle();
    chk(done_seen, "R7", "descriptor completed", 32'(recv_idx), 32'(c));
    chk(iss_idx == c, mode_tag(), "request count", 32'(iss_idx), 32'(c));
    while (backlog > 0) cycle();
    start = 1'b0;
  endtask

  task automatic err_case(input logic [31:0] b, input int c, input bit s, input bit d,
                          input logic [31:0] st, input string what);
    @(negedge clk);
    base_addr = b; word_count = CW'(c); strided = s; dbl = d; stride = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy && !mem_req, "R8", what, {29'h0, err, busy, mem_req}, 32'h4);
    @(negedge clk);
    chk(!err && !busy && !mem_req, "R8", {what, " settles"}, {29'h0, err, busy, mem_req}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    exp_slot = 0;
    backlog  = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !err, "R11", "state during reset",
        {28'h0, busy, mem_req, done, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !done && !err, "R11", "state after reset",
        {28'h0, busy, mem_req, done, err}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      run(V_BASE[v], V_CNT[v], V_STR[v], V_DBL[v], V_STRIDE[v], V_GMODE[v], V_RMODE[v], V_IGN[v], 0);
      if (V_FULL[v])
        chk(maxq == 8, "R5", "pending queue fills to depth", 32'(maxq), 32'd8);
      else
        chk(maxq <= 8, "R5", "pending queue bound", 32'(maxq), 32'd8);
      if (V_IGN[v])
        chk(iss_idx == V_CNT[v], "R9", "start while busy ignored", 32'(iss_idx), 32'(V_CNT[v]));
    end

    run(32'h7000, 20, 1'b0, 1'b0, 32'h0, 0, 0, 1'b0, 40);

    err_case(32'h102, 4, 1'b0, 1'b0, 32'h0, "misaligned base");
    err_case(32'h100, 0, 1'b0, 1'b0, 32'h0, "zero count");
    err_case(32'h100, 4, 1'b1, 1'b0, 32'h6, "misaligned stride");
    err_case(32'h100, 3, 1'b1, 1'b1, 32'h10, "odd count double");

    run(32'h9000, 3, 1'b0, 1'b0, 32'h0, 1, 3, 1'b0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule